// File: doc/BRIEF.md
# Programmable Watchdog Timer with Reset Steering

This block is a watchdog timer controlled through a single byte-wide configuration register. The byte packs a two-bit resolution field, a five-bit multiplier and a steering bit. The timeout, counted in ticks of an external 16 Hz enable, is the multiplier times four raised to the resolution. Software keeps the system alive by touching the register. Any write or any read of it restarts the countdown from the full interval and clears the watchdog flag.

When the countdown runs out, the block sets a sticky flag that software can read but cannot write. What happens next depends on the steering bit. With the bit set, the block issues a one-cycle system reset request and a one-cycle pulse that tells the calendar logic to clear its century bit, and it clears its own register to zero. With the bit clear, it emits a single one-cycle interrupt pulse and keeps the register value. In both cases the timer stops until the register is touched again.

A small bus selects between the configuration register and the flags register. Read data is combinational from the selected register. The tick generator and the reset logic that acts on the request are outside this block.

Top module: `wdog_steer`

## Requirements
- R1: The configuration byte decodes as resolution = bits [1:0] and multiplier = bits [6:2]. After a write, the timeout fires on exactly the (multiplier × 4^resolution)-th tick, and not on any earlier tick.
- R2: The countdown advances only in cycles where `tick_en` is high. Any number of cycles without a tick never causes a timeout.
- R3: A configuration value with a zero interval leaves the timer disarmed, and no timeout ever occurs. This covers writing 0 and any value with multiplier 0.
- R4: A write or a bus read (`bus_rd`) with `bus_sel`=0 clears the flag and restarts the countdown from the full interval of the register value. A kick in the same cycle as a would-be expiry wins, and no timeout occurs in that cycle.
- R5: On timeout the watchdog flag is set. It appears as bit 7 of the read data when `bus_sel`=1, and it stays set until the next kick.
- R6: If bit 7 of the register is 1 at timeout, `sys_rst_req` and `century_clr` pulse high for exactly one cycle, `irq_pulse` stays low, and the register reads 0 afterwards.
- R7: If bit 7 is 0 at timeout, `irq_pulse` is high for exactly one cycle, no reset request is made, the register keeps its value, and no further timeout occurs without a new kick.
- R8: Writes with `bus_sel`=1 do not change the flag, whether the flag is set or clear.
- R9: After block reset the register reads 0, the flag is 0, all pulse outputs are low, and the timer is disarmed, even if a countdown was running before the reset.
- R10: `bus_rdata` shows the configuration register when `bus_sel`=0. When `bus_sel`=1 it shows the flag in bit 7 with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | 16 Hz tick enable, one cycle wide |
| bus_sel | input | 1 | 0 = configuration register, 1 = flags register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (kicks when `bus_sel`=0) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| irq_pulse | output | 1 | One-cycle timeout interrupt |
| sys_rst_req | output | 1 | One-cycle system reset request |
| century_clr | output | 1 | One-cycle request to clear the century bit |

## Verification
The timeout count is checked against a table of configuration bytes. The table covers every resolution value, the smallest and largest multipliers, and both steering settings. A wrong field split, a wrong shift or an off-by-one in the count therefore shows up as a pulse on the wrong tick, and a swapped steering test shows up as the wrong pulse kind. Directed patterns separate the remaining cases: runs of idle cycles with no tick, kicks by read versus by write, a kick that lands on the expiry tick, writes aimed at the flags register, zero-interval values, and a reset in the middle of a count.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Bus register select encoding
    typedef enum logic {
        SEL_CFG   = 1'b0,
        SEL_FLAGS = 1'b1
    } wdog_sel_e;

    // Bit position of the flag inside the flags register read value
    localparam int FLAG_BIT = 7;

endpackage

// File: rtl/wdog_decode.sv
module wdog_decode #(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2,
    localparam int REG_W = RES_W + MULT_W + 1,
    localparam int CNT_W = MULT_W + 2 * ((1 << RES_W) - 1)
) (
    input  logic [REG_W-1:0] cfg,
    output logic [CNT_W-1:0] interval,
    output logic             steer
);

    logic [RES_W-1:0]  res;
    logic [MULT_W-1:0] mult;
    logic [CNT_W-1:0]  cand [1 << RES_W];

    assign res   = cfg[RES_W-1:0];
    assign mult  = cfg[RES_W +: MULT_W];
    assign steer = cfg[REG_W-1];

    // One candidate interval for each resolution setting
    for (genvar r = 0; r < (1 << RES_W); r++) begin : g_res
        assign cand[r] = CNT_W'(mult) << (2 * r);
    end

    assign interval = cand[res];

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expire
);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        expire  = 1'b0;
        if (load) begin
            state_d.armed = (load_val != '0);
            state_d.cnt   = load_val;
        end else if (state_q.armed && tick) begin
            if (state_q.cnt == CNT_W'(1)) begin
                expire        = 1'b1;
                state_d.armed = 1'b0;
                state_d.cnt   = '0;
            end else begin
                state_d.cnt = state_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/wdog_steer.sv
module wdog_steer #(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2,
    localparam int REG_W = RES_W + MULT_W + 1,
    localparam int CNT_W = MULT_W + 2 * ((1 << RES_W) - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             irq_pulse,
    output logic             sys_rst_req,
    output logic             century_clr
);
    import wdog_pkg::*;

    typedef struct packed {
        logic [REG_W-1:0] cfg;
        logic             flag;
        logic             irq;
        logic             rst_req;
    } top_state_t;

    top_state_t state_d, state_q;

    logic             kick_wr, kick_rd, kick;
    logic [REG_W-1:0] load_cfg;
    logic [CNT_W-1:0] load_val;
    logic             load_steer;
    logic             expire;

    assign kick_wr  = bus_wr && (bus_sel == SEL_CFG);
    assign kick_rd  = bus_rd && (bus_sel == SEL_CFG) && !bus_wr;
    assign kick     = kick_wr || kick_rd;
    assign load_cfg = kick_wr ? bus_wdata : state_q.cfg;

    wdog_decode #(
        .MULT_W (MULT_W),
        .RES_W  (RES_W)
    ) u_decode (
        .cfg      (load_cfg),
        .interval (load_val),
        .steer    (load_steer)
    );

    wdog_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (kick),
        .load_val (load_val),
        .tick     (tick_en),
        .expire   (expire)
    );

    always_comb begin
        state_d         = state_q;
        state_d.irq     = 1'b0;
        state_d.rst_req = 1'b0;
        if (kick_wr) begin
            state_d.cfg = bus_wdata;
        end
        if (kick) begin
            state_d.flag = 1'b0;
        end
        if (expire) begin
            state_d.flag = 1'b1;
            // Without a kick this cycle load_cfg is the stored register
            if (load_steer) begin
                state_d.cfg     = '0;
                state_d.rst_req = 1'b1;
            end else begin
                state_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        if (bus_sel == SEL_FLAGS) begin
            bus_rdata           = '0;
            bus_rdata[FLAG_BIT] = state_q.flag;
        end else begin
            bus_rdata = state_q.cfg;
        end
    end

    assign irq_pulse   = state_q.irq;
    assign sys_rst_req = state_q.rst_req;
    assign century_clr = state_q.rst_req;

endmodule

// File: rtl/wdog_steer_chk.sv
module wdog_steer_chk #(
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [REG_W-1:0] bus_wdata,
    input logic             irq_pulse,
    input logic             sys_rst_req,
    input logic [REG_W-1:0] cfg,
    input logic             flag
);

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !sys_rst_req); // R6
    AST_RST_CLEARS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> (cfg == '0)); // R6
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse); // R7
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_pulse && sys_rst_req)); // R7
    AST_FLAG_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse || sys_rst_req) |-> flag); // R5
    AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel && (bus_wr || bus_rd)) |=> (!flag && !irq_pulse && !sys_rst_req)); // R4
    AST_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel && bus_wr && bus_wdata == '0) |=> (cfg == '0 && !irq_pulse)); // R3
    AST_FLAG_ONLY_BY_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> (irq_pulse || sys_rst_req)); // R8

endmodule

bind wdog_steer wdog_steer_chk #(.REG_W(REG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_wdata   (bus_wdata),
    .irq_pulse   (irq_pulse),
    .sys_rst_req (sys_rst_req),
    .cfg         (state_q.cfg),
    .flag        (state_q.flag)
);

// File: tb/wdog_steer_bench.sv
module wdog_steer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_pulse, sys_rst_req, century_clr;

    int checks = 0;
    int fails  = 0;
    bit g_irq, g_rst, g_cen;

    always #2 clk = ~clk;

    wdog_steer u_wdog_steer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .irq_pulse   (irq_pulse),
        .sys_rst_req (sys_rst_req),
        .century_clr (century_clr)
    );

    // {config byte, expected tick count}
    localparam logic [23:0] VEC [8] = '{
        {8'h04, 16'd1},    // M=1  R=0
        {8'h05, 16'd4},    // M=1  R=1
        {8'h0E, 16'd48},   // M=3  R=2
        {8'h0B, 16'd128},  // M=2  R=3
        {8'h7C, 16'd31},   // M=31 R=0
        {8'h7F, 16'd1984}, // M=31 R=3
        {8'h8A, 16'd32},   // steer, M=2 R=2
        {8'hFD, 16'd124}   // steer, M=31 R=1
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // Inputs are driven 1 ns after a rising edge, outputs sampled 1 ns after the next
    task automatic cyc(input bit t, input bit wr, input bit rd, input bit sel, input logic [7:0] d);
        tick_en = t; bus_wr = wr; bus_rd = rd; bus_sel = sel; bus_wdata = d;
        @(posedge clk); #1;
        g_irq = irq_pulse; g_rst = sys_rst_req; g_cen = century_clr;
        tick_en = 0; bus_wr = 0; bus_rd = 0; bus_sel = 0;
    endtask

    // Apply n ticks; returns index (1-based) of first pulse of any kind, 0 if none
    task automatic ticks(input int n, output int first, output bit was_rst, output int pulses);
        first = 0; was_rst = 0; pulses = 0;
        for (int k = 1; k <= n; k++) begin
            cyc(1, 0, 0, 0, 8'h00);
            if (g_irq || g_rst) begin
                pulses++;
                if (first == 0) begin first = k; was_rst = g_rst; end
            end
        end
    endtask

    task automatic idle(input int n, output int pulses);
        pulses = 0;
        for (int k = 0; k < n; k++) begin
            cyc(0, 0, 0, 0, 8'h00);
            if (g_irq || g_rst) pulses++;
        end
    endtask

    task automatic flag_now(output int f);
        bus_sel = 1; #1; f = int'(bus_rdata); bus_sel = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run hung, actual running expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int first, pulses, f, cnt;
        bit was_rst;
        bit cen_seen;
        repeat (3) @(posedge clk); #1;
        // Reset state, R9 and R10
        bus_sel = 0; #1;
        chk(bus_rdata == 8'h00, "R9 reset cfg", bus_rdata, 0);
        bus_sel = 1; #1;
        chk(bus_rdata == 8'h00, "R9 reset flags", bus_rdata, 0);
        bus_sel = 0;
        chk({irq_pulse, sys_rst_req, century_clr} == 3'b000, "R9 reset outputs",
            {irq_pulse, sys_rst_req, century_clr}, 0);
        rst_n = 1;
        @(posedge clk); #1;

        // Table of intervals, R1 / R5 / R6 / R7 / R10
        for (int i = 0; i < 8; i++) begin
            logic [7:0] b;
            int n;
            b = VEC[i][23:16];
            n = int'(VEC[i][15:0]);
            cyc(0, 1, 0, 0, b);
            cen_seen = 0;
            first = 0; was_rst = 0;
            for (int k = 1; k <= n; k++) begin
                cyc(1, 0, 0, 0, 8'h00);
                if ((g_irq || g_rst) && first == 0) begin
                    first = k; was_rst = g_rst; cen_seen = g_cen;
                end
            end
            chk(first == n, "R1 timeout tick", first, n);
            chk(was_rst == b[7], b[7] ? "R6 reset steering" : "R7 irq steering", was_rst, b[7]);
            flag_now(f);
            chk(f == 8'h80, "R5 flag after timeout", f, 8'h80);
            bus_sel = 0; #1;
            chk(bus_rdata == (b[7] ? 8'h00 : b), "R10 cfg readback after timeout", bus_rdata, b[7] ? 0 : b);
            if (b[7]) chk(cen_seen, "R6 century_clr with reset", cen_seen, 1);
        end

        // R6: reset and century pulses last one cycle
        cyc(0, 1, 0, 0, 8'h84);
        cyc(1, 0, 0, 0, 8'h00);
        chk(g_rst && g_cen && !g_irq, "R6 reset pulse", {g_irq, g_rst, g_cen}, 3'b011);
        cyc(0, 0, 0, 0, 8'h00);
        chk(!g_rst && !g_cen, "R6 one-cycle reset pulse", {g_rst, g_cen}, 0);

        // R7: irq lasts one cycle and timer stops afterwards
        cyc(0, 1, 0, 0, 8'h04);
        cyc(1, 0, 0, 0, 8'h00);
        chk(g_irq && !g_rst, "R7 irq pulse", {g_irq, g_rst}, 2'b10);
        cyc(0, 0, 0, 0, 8'h00);
        chk(!g_irq, "R7 one-cycle irq", g_irq, 0);
        ticks(10, first, was_rst, pulses);
        chk(pulses == 0, "R7 no second timeout", pulses, 0);

        // R8: flags register ignores writes (flag currently set)
        cyc(0, 1, 0, 1, 8'h00);
        flag_now(f);
        chk(f == 8'h80, "R8 flag survives write of 0", f, 8'h80);
        // R4: read clears flag and rearms (cfg still 0x04, interval 1)
        cyc(0, 0, 1, 0, 8'h00);
        flag_now(f);
        chk(f == 8'h00, "R4 read clears flag", f, 0);
        cyc(1, 0, 0, 0, 8'h00);
        chk(g_irq, "R4 read rearms", g_irq, 1);
        // R8 with flag clear
        cyc(0, 1, 0, 0, 8'h04);
        cyc(0, 1, 0, 1, 8'hFF);
        flag_now(f);
        chk(f == 8'h00, "R8 flag stays clear on write", f, 0);

        // R2: no ticks, no timeout
        idle(40, pulses);
        chk(pulses == 0, "R2 idle cycles do not count", pulses, 0);
        cyc(1, 0, 0, 0, 8'h00);
        chk(g_irq, "R2 timeout on the tick", g_irq, 1);

        // R4: kick by read restarts full interval (M=2 R=0, N=2)
        cyc(0, 1, 0, 0, 8'h08);
        cyc(1, 0, 0, 0, 8'h00);
        cyc(0, 0, 1, 0, 8'h00);
        ticks(1, first, was_rst, pulses);
        chk(pulses == 0, "R4 read restarts count", pulses, 0);
        ticks(1, first, was_rst, pulses);
        chk(pulses == 1, "R4 timeout after full interval", pulses, 1);

        // R4: kick on the expiry tick wins
        cyc(0, 1, 0, 0, 8'h04);
        cyc(1, 0, 1, 0, 8'h00);
        chk(!g_irq && !g_rst, "R4 kick beats expiry", {g_irq, g_rst}, 0);
        cyc(1, 0, 0, 0, 8'h00);
        chk(g_irq, "R4 timeout after collision", g_irq, 1);

        // R3: zero value and zero multiplier stay disarmed
        cyc(0, 1, 0, 0, 8'h00);
        ticks(100, first, was_rst, pulses);
        chk(pulses == 0, "R3 zero write disarms", pulses, 0);
        cyc(0, 1, 0, 0, 8'h03);
        ticks(100, first, was_rst, pulses);
        chk(pulses == 0, "R3 zero multiplier disarms", pulses, 0);

        // R9: reset mid-count
        cyc(0, 1, 0, 0, 8'h08);
        cyc(1, 0, 0, 0, 8'h00);
        rst_n = 0;
        cyc(0, 0, 0, 0, 8'h00);
        cyc(0, 0, 0, 0, 8'h00);
        rst_n = 1;
        bus_sel = 0; #1;
        chk(bus_rdata == 8'h00, "R9 cfg cleared by reset", bus_rdata, 0);
        ticks(5, first, was_rst, pulses);
        chk(pulses == 0, "R9 disarmed after reset", pulses, 0);

        cnt = checks;
        $display("%0d/%0d checks passed", cnt - fails, cnt);
        $finish;
    end

endmodule